// File: doc/BRIEF.md
# Binary and Packed-Decimal Arithmetic Unit

This block is the arithmetic slice of an 8-bit datapath. It is purely combinational. It takes an accumulator byte, an operand byte, a carry input, a decimal-mode flag and a 3-bit operation code. In the same cycle it returns a result byte and the four condition flags: negative (N), zero (Z), carry (C) and overflow (V). Each flag comes with its own write strobe, and the result has a write strobe too. The surrounding register file updates only what the operation actually defines.

Four operations are supported:

- **Add with carry.**
- **Subtract with borrow.** The borrow is the inverse of the carry input.
- **Compare.** This is a subtraction that keeps only the flags.
- **Bit test.** The flags come from the operand and from its AND with the accumulator.

When the decimal flag is set, add and subtract treat both bytes as two packed BCD digits. Compare and bit test ignore the decimal flag. Addressing, register storage and instruction sequencing belong to the caller. For compare, the caller places the register being compared on `acc_i`.

Top module: `bcd_arith_unit`

## Requirements
- R1: With op_i=0 (add) and dec_i=0, res_o is the low byte of acc_i+opnd_i+carry_i, and c_o is bit 8 of that sum. n_o is result bit 7 and z_o is set when the result byte is zero.
- R2: For add, v_o is set exactly when the two inputs have the same sign bit and the sign bit of the sum differs from it. In binary add this is the same as the signed sum leaving the range -128..127.
- R3: With op_i=0 and dec_i=1, and both inputs valid packed BCD, res_o is the packed-BCD value of (acc+opnd+carry) mod 100. c_o is set when that decimal total is 100 or more.
- R4: Decimal add flags are produced by three sums:
  - L is the low nibbles plus carry_i.
  - H is the high nibbles kept in place (each nibble times 16, added).
  - When L > 9, 0x10 is added to H, giving H'.

  z_o is set when the low byte of L+H is zero. n_o is bit 7 of H'. v_o is (~(acc^opnd) & (acc^H')) bit 7.
- R5: With op_i=1 (subtract) and dec_i=0, the borrow is NOT carry_i, and res_o is the low byte of acc-opnd-borrow. c_o is set when no borrow out occurs. n_o and z_o come from the result byte. v_o is ((acc^opnd) & (acc^res)) bit 7.
- R6: With op_i=1 and dec_i=1, and valid BCD inputs, res_o is the packed-BCD value of (acc-opnd-borrow) mod 100. N, Z, C and V are the same as for the binary difference of R5.
- R7: With op_i=2 (compare), the unit forms acc-opnd with no borrow:
  - n_o is bit 7 of the difference.
  - z_o is set when the difference is zero.
  - c_o is set when acc >= opnd.

  Only the N, Z and C strobes are high, res_we_o is low, res_o equals acc_i, and dec_i has no effect.
- R8: With op_i=3 (bit test), n_o is opnd bit 7, v_o is opnd bit 6, and z_o is set when (acc AND opnd) is zero. Only the N, Z and V strobes are high, res_we_o is low, res_o equals acc_i, and dec_i has no effect.
- R9: Add and subtract raise res_we_o and all four flag strobes. Op codes 4 to 7 raise no strobe and pass acc_i to res_o.
- R10: The outputs depend only on the present inputs. The same inputs give the same outputs whatever was applied before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_i | input | 8 | Accumulator, or the register being compared |
| opnd_i | input | 8 | Memory or immediate operand |
| carry_i | input | 1 | Carry in; its inverse is the subtract borrow |
| dec_i | input | 1 | Packed-BCD mode for add and subtract |
| op_i | input | 3 | 0 add, 1 subtract, 2 compare, 3 bit test, others idle |
| res_o | output | 8 | Result byte (acc_i when not written) |
| res_we_o | output | 1 | Result write strobe |
| n_o | output | 1 | Negative flag value |
| z_o | output | 1 | Zero flag value |
| c_o | output | 1 | Carry flag value |
| v_o | output | 1 | Overflow flag value |
| n_we_o | output | 1 | Negative flag write strobe |
| z_we_o | output | 1 | Zero flag write strobe |
| c_we_o | output | 1 | Carry flag write strobe |
| v_we_o | output | 1 | Overflow flag write strobe |

## Verification
The unit holds no state, so a fault can only be a wrong adjust term, a wrong sign tap or a wrong strobe. Any of these shows at the ports in the same cycle as the inputs that reach it. A bad decimal correction appears only on operand pairs whose low digits sum past 9 or go below 0. A bad high-digit correction appears only when the high sum passes 9. For this reason the decimal sweeps cover every BCD pair with both carry values in rotation. A stale or swapped strobe is caught on every compare and bit-test vector, because the expected strobe pattern differs for each op code.

// File: rtl/bcd_arith_unit.sv
module bcd_arith_unit (
  input  logic [7:0] acc_i,
  input  logic [7:0] opnd_i,
  input  logic       carry_i,
  input  logic       dec_i,
  input  logic [2:0] op_i,
  output logic [7:0] res_o,
  output logic       res_we_o,
  output logic       n_o,
  output logic       z_o,
  output logic       c_o,
  output logic       v_o,
  output logic       n_we_o,
  output logic       z_we_o,
  output logic       c_we_o,
  output logic       v_we_o
);
  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_SUB = 3'd1;
  localparam logic [2:0] OP_CMP = 3'd2;
  localparam logic [2:0] OP_BIT = 3'd3;

  logic       brw;
  logic [8:0] bsum, bdif, cdif;
  assign brw  = ~carry_i;
  assign bsum = {1'b0, acc_i} + {1'b0, opnd_i} + {8'b0, carry_i};
  assign bdif = {1'b0, acc_i} - {1'b0, opnd_i} - {8'b0, brw};
  assign cdif = {1'b0, acc_i} - {1'b0, opnd_i};

  // decimal add: low digit sum, high digit sum counted in units of 0x10
  logic [4:0] alo0;
  logic [3:0] alo;
  logic [4:0] ahs0;
  logic [5:0] ahs1, ahs;
  logic [7:0] atot;
  logic       alo_fix;
  assign alo0    = {1'b0, acc_i[3:0]} + {1'b0, opnd_i[3:0]} + {4'b0, carry_i};
  assign ahs0    = {1'b0, acc_i[7:4]} + {1'b0, opnd_i[7:4]};
  assign atot    = {ahs0[3:0], 4'b0} + {3'b0, alo0};
  assign alo_fix = alo0 > 5'd9;
  assign alo     = alo_fix ? alo0[3:0] + 4'd6 : alo0[3:0];
  assign ahs1    = {1'b0, ahs0} + {5'b0, alo_fix};
  assign ahs     = (ahs1 > 6'd9) ? ahs1 + 6'd6 : ahs1;

  // decimal subtract: per-digit difference with borrow chain
  logic [4:0] slo0, shi0;
  logic [3:0] slo, shi;
  assign slo0 = {1'b0, acc_i[3:0]} - {1'b0, opnd_i[3:0]} - {4'b0, brw};
  assign slo  = slo0[4] ? slo0[3:0] - 4'd6 : slo0[3:0];
  assign shi0 = {1'b0, acc_i[7:4]} - {1'b0, opnd_i[7:4]} - {4'b0, slo0[4]};
  assign shi  = shi0[4] ? shi0[3:0] - 4'd6 : shi0[3:0];

  always_comb begin
    res_o    = acc_i;
    res_we_o = 1'b0;
    {n_o, z_o, c_o, v_o}             = 4'b0;
    {n_we_o, z_we_o, c_we_o, v_we_o} = 4'b0;
    case (op_i)
      OP_ADD: begin
        res_we_o = 1'b1;
        {n_we_o, z_we_o, c_we_o, v_we_o} = 4'b1111;
        if (dec_i) begin
          res_o = {ahs[3:0], alo};
          n_o   = ahs1[3];
          z_o   = (atot == 8'd0);
          c_o   = |ahs[5:4];
          v_o   = ~(acc_i[7] ^ opnd_i[7]) & (acc_i[7] ^ ahs1[3]);
        end else begin
          res_o = bsum[7:0];
          n_o   = bsum[7];
          z_o   = (bsum[7:0] == 8'd0);
          c_o   = bsum[8];
          v_o   = ~(acc_i[7] ^ opnd_i[7]) & (acc_i[7] ^ bsum[7]);
        end
      end
      OP_SUB: begin
        res_we_o = 1'b1;
        {n_we_o, z_we_o, c_we_o, v_we_o} = 4'b1111;
        res_o = dec_i ? {shi, slo} : bdif[7:0];
        n_o   = bdif[7];
        z_o   = (bdif[7:0] == 8'd0);
        c_o   = ~bdif[8];
        v_o   = (acc_i[7] ^ opnd_i[7]) & (acc_i[7] ^ bdif[7]);
      end
      OP_CMP: begin
        {n_we_o, z_we_o, c_we_o} = 3'b111;
        n_o = cdif[7];
        z_o = (cdif[7:0] == 8'd0);
        c_o = ~cdif[8];
      end
      OP_BIT: begin
        {n_we_o, z_we_o, v_we_o} = 3'b111;
        n_o = opnd_i[7];
        v_o = opnd_i[6];
        z_o = ((acc_i & opnd_i) == 8'd0);
      end
      default: ;
    endcase
  end

  always_comb begin
    if (op_i == OP_ADD && !dec_i)
      p_bin_zero_r1: assert (z_o == (res_o == 8'd0));
    if (op_i == OP_ADD && dec_i && acc_i[3:0] < 4'd10 && acc_i[7:4] < 4'd10
        && opnd_i[3:0] < 4'd10 && opnd_i[7:4] < 4'd10)
      p_bcd_digits_r3: assert (res_o[3:0] < 4'd10 && res_o[7:4] < 4'd10);
    if (op_i == OP_SUB && !dec_i && carry_i)
      p_sub_carry_r5: assert (c_o == (acc_i >= opnd_i));
    if (op_i == OP_CMP)
      p_cmp_nowrite_r7: assert (!res_we_o && !v_we_o && res_o == acc_i);
    if (op_i == OP_BIT)
      p_bit_keep_r8: assert (!res_we_o && !c_we_o && res_o == acc_i && v_o == opnd_i[6]);
    if (op_i[2])
      p_idle_quiet_r9: assert (!res_we_o && !n_we_o && !z_we_o && !c_we_o && !v_we_o);
  end
endmodule

// File: tb/tb_bcd_arith_unit.sv
module tb_bcd_arith_unit;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [7:0] acc_i = 8'd0, opnd_i = 8'd0;
  logic       carry_i = 1'b0, dec_i = 1'b0;
  logic [2:0] op_i = 3'd4;
  logic [7:0] res_o;
  logic       res_we_o, n_o, z_o, c_o, v_o, n_we_o, z_we_o, c_we_o, v_we_o;

  bcd_arith_unit dut (
    .acc_i(acc_i), .opnd_i(opnd_i), .carry_i(carry_i), .dec_i(dec_i), .op_i(op_i),
    .res_o(res_o), .res_we_o(res_we_o), .n_o(n_o), .z_o(z_o), .c_o(c_o), .v_o(v_o),
    .n_we_o(n_we_o), .z_we_o(z_we_o), .c_we_o(c_we_o), .v_we_o(v_we_o)
  );

  typedef struct {
    logic [7:0] res;
    logic       rwe;
    logic [3:0] flg;
    logic [3:0] we;
    string      rtag;
    string      ftag;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0;
  bit done = 0;

  function automatic int bcd2i(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] i2bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic exp_t m_add(input logic [7:0] a, m, input logic c, d);
    exp_t e;
    int s, sa, lo, hi, t;
    e.rwe = 1'b1; e.we = 4'b1111;
    if (!d) begin
      s  = int'(a) + int'(m) + int'(c);
      sa = int'($signed(a)) + int'($signed(m)) + int'(c);
      e.res = 8'(s);
      e.flg = {e.res[7], e.res == 8'd0, s > 255, (sa > 127 || sa < -128)};
      e.rtag = "R1"; e.ftag = "R2";
    end else begin
      t = bcd2i(a) + bcd2i(m) + int'(c);
      e.res = i2bcd(t % 100);
      lo = int'(a[3:0]) + int'(m[3:0]) + int'(c);
      hi = int'(a & 8'hf0) + int'(m & 8'hf0);
      e.flg[2] = ((lo + hi) % 256) == 0;
      if (lo > 9) hi = hi + 16;
      e.flg[3] = (hi / 128) % 2 == 1;
      e.flg[0] = (a[7] == m[7]) && (a[7] != ((hi / 128) % 2 == 1));
      e.flg[1] = t >= 100;
      e.rtag = "R3"; e.ftag = "R4";
    end
    return e;
  endfunction

  function automatic exp_t m_sub(input logic [7:0] a, m, input logic c, d);
    exp_t e;
    int df, sd, t;
    df = int'(a) - int'(m) - int'(!c);
    sd = int'($signed(a)) - int'($signed(m)) - int'(!c);
    e.rwe = 1'b1; e.we = 4'b1111;
    e.flg = {df[7], (df & 255) == 0, df >= 0, (sd > 127 || sd < -128)};
    if (d) begin
      t = bcd2i(a) - bcd2i(m) - int'(!c);
      if (t < 0) t = t + 100;
      e.res = i2bcd(t);
      e.rtag = "R6"; e.ftag = "R6";
    end else begin
      e.res = 8'(df);
      e.rtag = "R5"; e.ftag = "R5";
    end
    return e;
  endfunction

  function automatic exp_t m_cmp(input logic [7:0] a, m);
    exp_t e;
    e.res = a; e.rwe = 1'b0; e.we = 4'b1110;
    e.flg = {8'(a - m) >= 8'h80, a == m, a >= m, 1'b0};
    e.rtag = "R7"; e.ftag = "R7";
    return e;
  endfunction

  function automatic exp_t m_bit(input logic [7:0] a, m);
    exp_t e;
    e.res = a; e.rwe = 1'b0; e.we = 4'b1101;
    e.flg = {m[7], (a & m) == 8'd0, 1'b0, m[6]};
    e.rtag = "R8"; e.ftag = "R8";
    return e;
  endfunction

  function automatic exp_t m_idle(input logic [7:0] a);
    exp_t e;
    e.res = a; e.rwe = 1'b0; e.we = 4'b0000; e.flg = 4'b0;
    e.rtag = "R9"; e.ftag = "R9";
    return e;
  endfunction

  task automatic drive(input logic [2:0] op, input logic [7:0] a, m, input logic c, d, input exp_t e);
    @(negedge clk);
    op_i = op; acc_i = a; opnd_i = m; carry_i = c; dec_i = d;
    q.push_back(e);
  endtask

  task automatic go(input logic [2:0] op, input logic [7:0] a, m, input logic c, d);
    case (op)
      3'd0: drive(op, a, m, c, d, m_add(a, m, c, d));
      3'd1: drive(op, a, m, c, d, m_sub(a, m, c, d));
      3'd2: drive(op, a, m, c, d, m_cmp(a, m));
      3'd3: drive(op, a, m, c, d, m_bit(a, m));
      default: drive(op, a, m, c, d, m_idle(a));
    endcase
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      logic [3:0] gf, gw;
      e = q.pop_front();
      gf = {n_o, z_o, c_o, v_o};
      gw = {n_we_o, z_we_o, c_we_o, v_we_o};
      total++;
      if (res_o !== e.res || res_we_o !== e.rwe) begin
        bad++;
        $display("FAIL %s res/we got %h/%b exp %h/%b (op %0d a %h m %h c %b d %b)",
                 e.rtag, res_o, res_we_o, e.res, e.rwe, op_i, acc_i, opnd_i, carry_i, dec_i);
      end else if (gw !== e.we || ((gf ^ e.flg) & e.we) != 4'b0) begin
        bad++;
        $display("FAIL %s nzcv/we got %b/%b exp %b/%b (op %0d a %h m %h c %b d %b)",
                 e.ftag, gf, gw, e.flg, e.we, op_i, acc_i, opnd_i, carry_i, dec_i);
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired, %0d items pending", q.size());
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R9: idle op before any arithmetic, and every idle code
    for (int k = 4; k < 8; k++) go(3'(k), 8'h5a, 8'hff, 1'b1, 1'b1);
    // R1 R2 binary add corners
    go(3'd0, 8'hff, 8'h00, 1'b1, 1'b0);
    go(3'd0, 8'h7f, 8'h01, 1'b0, 1'b0);
    go(3'd0, 8'h80, 8'h80, 1'b0, 1'b0);
    // R3 R4 decimal add corners
    go(3'd0, 8'h99, 8'h99, 1'b1, 1'b1);
    go(3'd0, 8'h50, 8'h50, 1'b0, 1'b1);
    go(3'd0, 8'h09, 8'h01, 1'b0, 1'b1);
    // R5 R6 subtract corners
    go(3'd1, 8'h00, 8'h00, 1'b0, 1'b0);
    go(3'd1, 8'h00, 8'h01, 1'b1, 1'b1);
    go(3'd1, 8'h80, 8'h01, 1'b1, 1'b0);
    // R10: same input after different history
    go(3'd0, 8'h45, 8'h38, 1'b1, 1'b1);
    go(3'd1, 8'hff, 8'h00, 1'b0, 1'b0);
    go(3'd0, 8'h45, 8'h38, 1'b1, 1'b1);
    // R1 R2 binary add sweep
    for (int a = 0; a < 256; a++)
      for (int m = 0; m < 256; m += 2)
        go(3'd0, 8'(a), 8'(m), 1'((a ^ (m >> 1)) & 1), 1'b0);
    // R3 R4 decimal add over all BCD pairs
    for (int a = 0; a < 100; a++)
      for (int m = 0; m < 100; m++)
        go(3'd0, i2bcd(a), i2bcd(m), 1'((a + m) & 1), 1'b1);
    // R5 binary subtract sweep
    for (int a = 0; a < 256; a++)
      for (int m = 0; m < 256; m += 3)
        go(3'd1, 8'(a), 8'(m), 1'((a + m) & 1), 1'b0);
    // R6 decimal subtract over all BCD pairs
    for (int a = 0; a < 100; a++)
      for (int m = 0; m < 100; m++)
        go(3'd1, i2bcd(a), i2bcd(m), 1'((a ^ m) & 1), 1'b1);
    // R7 compare, dec_i toggled to show it is ignored
    for (int a = 0; a < 256; a++)
      for (int m = 0; m < 256; m += 5)
        go(3'd2, 8'(a), 8'(m), 1'(m & 1), 1'(a & 1));
    go(3'd2, 8'h42, 8'h42, 1'b0, 1'b1);
    // R8 bit test, dec_i toggled to show it is ignored
    for (int a = 0; a < 256; a++)
      for (int m = 0; m < 256; m += 5)
        go(3'd3, 8'(a), 8'(m), 1'(a & 1), 1'(m & 1));
    go(3'd3, 8'h0f, 8'hc0, 1'b1, 1'b1);
    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule